// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is a synchronous model of the command decoder and write state machine of a byte-wide parallel NOR flash. Bus write cycles carry an address and a data byte. The decoder turns these into single-cycle commands (clear status, select status read, select array read, suspend, resume) and two-cycle commands (byte program, block erase). A small register array inside the block stands in for the flash cells. Program and erase complete after fixed, parameterised busy times.

Reads are combinational on the address. They return either array data or the status byte, depending on the current read mode. Status bit 7 is mirrored on a ready/busy output. Error bits record why an operation was refused: a bad command sequence, a low programming voltage, or a locked block. Each cause is paired with an erase-fail or program-fail bit.

An erase in progress can be suspended. While it is suspended, other blocks can be read or programmed, and a resume command continues the erase from where it stopped.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, ready_o is 1, the read mode is array, every array byte reads FFh, and the status byte reads 80h. Status bit map: bit 7 ready, bit 6 erase suspended, bit 5 erase fail, bit 4 program fail, bit 3 voltage low, bit 1 block locked; bits 2 and 0 always read 0.
- R2: Writing 40h or 10h and then a second write (address, data) starts a program. ready_o is 0 from that write edge until exactly PROG_CYC clock edges later. The stored byte then equals the old byte AND the data, because bits can only be cleared. No program-fail bit is raised for a 1 written over a 0.
- R3: After 40h, 10h, 20h, B0h or D0h is written, reads return the status byte. 70h also selects status reads, and FFh selects array reads. The read mode holds until one of these commands changes it.
- R4: Writing 20h and then D0h to an address starts an erase of that address's block (the top BLK_W address bits). ERASE_CYC running edges later, every byte of that block reads FFh and all other blocks are unchanged.
- R5: If the write after 20h is not D0h, status bits 5 and 4 are set, no erase starts, ready_o stays 1 and the array is unchanged.
- R6: With vpp_ok_i low, a program sets status bits 4 and 3, and an erase sets status bits 5 and 3. Neither starts, and the array is unchanged.
- R7: If the target block's lock_i bit is set and hv_override_i is 0, a program sets bits 4 and 1, and an erase sets bits 5 and 1; nothing starts. With hv_override_i at 1, the operation proceeds.
- R8: Error bits 5, 4, 3 and 1 stay set across other commands until 50h is written, which clears all four.
- R9: B0h written during an erase stops erase progress. SUSP_LAT edges later, status bits 7 and 6 read 1 and ready_o is 1. Until then, ready_o stays 0.
- R10: While the erase is suspended, FFh allows array reads of other blocks, and a program to another block runs normally with status bit 6 held at 1.
- R11: While the erase is suspended, a program aimed at the suspended block sets status bit 4 and changes nothing. An array-mode read of an address in the suspended block returns the status byte.
- R12: D0h written while suspended resumes the erase and clears bit 6. The erase completes after the running edges that were still remaining when it was suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe, sampled on the rising edge |
| addr_i | input | ADDR_W | Address for writes and for combinational reads |
| wdata_i | input | 8 | Command or program data |
| vpp_ok_i | input | 1 | Programming voltage is adequate |
| hv_override_i | input | 1 | High-voltage override that bypasses block locks |
| lock_i | input | 2**BLK_W | Per-block lock bits |
| rdata_o | output | 8 | Array byte or status byte |
| ready_o | output | 1 | Ready (1) or busy (0) |

## Verification
Command and error effects are registered on the write edge. The bench therefore checks them at the falling edge that follows the write. A program's busy window is probed at PROG_CYC-1 edges after the data write, where busy is expected, and again at PROG_CYC edges, where ready is expected. The erase window and the suspend latency are probed the same way with ERASE_CYC and SUSP_LAT.

For suspend and resume, the bench counts the running edges spent before the suspend command. It then expects completion exactly after the remaining count following the resume edge. Reads are combinational, so they are sampled one time step after the address changes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int DATA_W = 8;

  localparam logic [7:0] OP_PROG     = 8'h40;
  localparam logic [7:0] OP_PROG_ALT = 8'h10;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_SUSPEND  = 8'hB0;
  localparam logic [7:0] OP_CLR      = 8'h50;
  localparam logic [7:0] OP_RD_STAT  = 8'h70;
  localparam logic [7:0] OP_RD_ARR   = 8'hFF;

  // error set/hold vector index
  localparam int E_ERASE = 3;
  localparam int E_PROG  = 2;
  localparam int E_VPP   = 1;
  localparam int E_LOCK  = 0;

  typedef enum logic [2:0] {
    WS_READY, WS_PROG, WS_ERASE, WS_SUSP_PEND, WS_SUSPENDED, WS_PROG_SUSP
  } wsm_e;

  typedef enum logic [1:0] {
    CS_IDLE, CS_PROG_ARM, CS_ERASE_ARM
  } cui_e;
endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == CNT_W'(1));

  // R12
  timer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !run_i) |=> $stable(cnt_q));
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import flash_cmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  set_i,
  input  logic        clr_i,
  input  logic        ready_i,
  input  logic        susp_i,
  output logic [7:0]  status_o
);
  logic [3:0] err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= '0;
    else if (clr_i)  err_q <= '0;
    else             err_q <= err_q | set_i;
  end

  assign status_o = {ready_i, susp_i, err_q[E_ERASE], err_q[E_PROG],
                     err_q[E_VPP], 1'b0, err_q[E_LOCK], 1'b0};

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && set_i == '0) |=> (err_q == $past(err_q)));
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BLK_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_en_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              erase_en_i,
  input  logic [BLK_W-1:0]  erase_blk_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int OFF_W = ADDR_W - BLK_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (erase_en_i) begin
      for (int i = 0; i < DEPTH; i++)
        if ((i >> OFF_W) == int'(erase_blk_i)) mem[i] <= '1;
    end else if (prog_en_i) begin
      mem[prog_addr_i] <= mem[prog_addr_i] & prog_data_i;
    end
  end

  assign rd_data_o = mem[rd_addr_i];

  // R2
  prog_clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_en_i && !erase_en_i) |=>
      ((mem[$past(prog_addr_i)] & ~$past(prog_data_i)) == '0));

  // R4
  erase_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_en_i |=> (mem[{$past(erase_blk_i), {OFF_W{1'b0}}}] == '1));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BLK_W     = 2,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 16,
  parameter int SUSP_LAT  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [7:0]              wdata_i,
  input  logic                    vpp_ok_i,
  input  logic                    hv_override_i,
  input  logic [(1<<BLK_W)-1:0]   lock_i,
  output logic [7:0]              rdata_o,
  output logic                    ready_o
);
  localparam int MAX_A   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int MAX_CYC = (MAX_A > SUSP_LAT) ? MAX_A : SUSP_LAT;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  wsm_e              wsm_q, wsm_d;
  cui_e              cui_q, cui_d;
  logic              rd_status_q, rd_status_d;
  logic [ADDR_W-1:0] tgt_addr_q, tgt_addr_d;
  logic [7:0]        tgt_data_q, tgt_data_d;
  logic [BLK_W-1:0]  erase_blk_q, erase_blk_d;

  logic [3:0] err_set;
  logic       err_clr, prog_load, erase_load, susp_load;
  logic       prog_commit, erase_commit;
  logic       prog_done, erase_done, susp_done;
  logic [7:0] status, array_rd;

  logic [BLK_W-1:0] wr_blk, tgt_blk;
  logic suspended, idle_ok;

  assign wr_blk    = addr_i[ADDR_W-1 -: BLK_W];
  assign tgt_blk   = tgt_addr_q[ADDR_W-1 -: BLK_W];
  assign suspended = (wsm_q == WS_SUSPENDED) || (wsm_q == WS_PROG_SUSP);
  assign idle_ok   = (wsm_q == WS_READY) || (wsm_q == WS_SUSPENDED);
  assign ready_o   = idle_ok;

  always_comb begin
    wsm_d        = wsm_q;
    cui_d        = cui_q;
    rd_status_d  = rd_status_q;
    tgt_addr_d   = tgt_addr_q;
    tgt_data_d   = tgt_data_q;
    erase_blk_d  = erase_blk_q;
    err_set      = '0;
    err_clr      = 1'b0;
    prog_load    = 1'b0;
    erase_load   = 1'b0;
    susp_load    = 1'b0;
    prog_commit  = 1'b0;
    erase_commit = 1'b0;

    // busy-side sequencing
    case (wsm_q)
      WS_PROG: if (prog_done) begin
        wsm_d = WS_READY;
        prog_commit = 1'b1;
      end
      WS_PROG_SUSP: if (prog_done) begin
        wsm_d = WS_SUSPENDED;
        prog_commit = 1'b1;
      end
      WS_ERASE: begin
        if (erase_done) begin
          wsm_d = WS_READY;
          erase_commit = 1'b1;
        end else if (wr_en_i && wdata_i == OP_SUSPEND) begin
          wsm_d = WS_SUSP_PEND;
          susp_load = 1'b1;
          rd_status_d = 1'b1;
        end
      end
      WS_SUSP_PEND: if (susp_done) wsm_d = WS_SUSPENDED;
      default: ;
    endcase

    if (wr_en_i && !idle_ok && wdata_i == OP_RD_STAT) rd_status_d = 1'b1;

    // command decode when able to accept
    if (wr_en_i && idle_ok) begin
      case (cui_q)
        CS_PROG_ARM: begin
          cui_d = CS_IDLE;
          rd_status_d = 1'b1;
          if (suspended && wr_blk == erase_blk_q) begin
            err_set[E_PROG] = 1'b1;
          end else if (!vpp_ok_i) begin
            err_set[E_PROG] = 1'b1;
            err_set[E_VPP]  = 1'b1;
          end else if (lock_i[wr_blk] && !hv_override_i) begin
            err_set[E_PROG] = 1'b1;
            err_set[E_LOCK] = 1'b1;
          end else begin
            tgt_addr_d = addr_i;
            tgt_data_d = wdata_i;
            prog_load  = 1'b1;
            wsm_d      = suspended ? WS_PROG_SUSP : WS_PROG;
          end
        end
        CS_ERASE_ARM: begin
          cui_d = CS_IDLE;
          rd_status_d = 1'b1;
          if (wdata_i != OP_CONFIRM) begin
            err_set[E_ERASE] = 1'b1;
            err_set[E_PROG]  = 1'b1;
          end else if (!vpp_ok_i) begin
            err_set[E_ERASE] = 1'b1;
            err_set[E_VPP]   = 1'b1;
          end else if (lock_i[wr_blk] && !hv_override_i) begin
            err_set[E_ERASE] = 1'b1;
            err_set[E_LOCK]  = 1'b1;
          end else begin
            erase_blk_d = wr_blk;
            erase_load  = 1'b1;
            wsm_d       = WS_ERASE;
          end
        end
        default: begin
          case (wdata_i)
            OP_PROG, OP_PROG_ALT: begin
              cui_d = CS_PROG_ARM;
              rd_status_d = 1'b1;
            end
            OP_ERASE: if (!suspended) begin
              cui_d = CS_ERASE_ARM;
              rd_status_d = 1'b1;
            end
            OP_CONFIRM: if (suspended) begin
              wsm_d = WS_ERASE;
              rd_status_d = 1'b1;
            end
            OP_CLR:     err_clr = 1'b1;
            OP_RD_STAT: rd_status_d = 1'b1;
            OP_RD_ARR:  rd_status_d = 1'b0;
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wsm_q       <= WS_READY;
      cui_q       <= CS_IDLE;
      rd_status_q <= 1'b0;
      tgt_addr_q  <= '0;
      tgt_data_q  <= '0;
      erase_blk_q <= '0;
    end else begin
      wsm_q       <= wsm_d;
      cui_q       <= cui_d;
      rd_status_q <= rd_status_d;
      tgt_addr_q  <= tgt_addr_d;
      tgt_data_q  <= tgt_data_d;
      erase_blk_q <= erase_blk_d;
    end
  end

  flash_op_timer #(.CNT_W(CNT_W)) prog_tmr_i (
    .clk_i, .rst_ni, .load_i(prog_load), .load_val_i(CNT_W'(PROG_CYC)),
    .run_i((wsm_q == WS_PROG) || (wsm_q == WS_PROG_SUSP)), .done_o(prog_done));

  flash_op_timer #(.CNT_W(CNT_W)) erase_tmr_i (
    .clk_i, .rst_ni, .load_i(erase_load), .load_val_i(CNT_W'(ERASE_CYC)),
    .run_i(wsm_q == WS_ERASE), .done_o(erase_done));

  flash_op_timer #(.CNT_W(CNT_W)) susp_tmr_i (
    .clk_i, .rst_ni, .load_i(susp_load), .load_val_i(CNT_W'(SUSP_LAT)),
    .run_i(wsm_q == WS_SUSP_PEND), .done_o(susp_done));

  flash_status_reg status_i (
    .clk_i, .rst_ni, .set_i(err_set), .clr_i(err_clr),
    .ready_i(ready_o), .susp_i(suspended), .status_o(status));

  flash_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) array_i (
    .clk_i, .rst_ni,
    .prog_en_i(prog_commit), .prog_addr_i(tgt_addr_q), .prog_data_i(tgt_data_q),
    .erase_en_i(erase_commit), .erase_blk_i(erase_blk_q),
    .rd_addr_i(addr_i), .rd_data_o(array_rd));

  assign rdata_o = (rd_status_q || (suspended && wr_blk == erase_blk_q)) ? status : array_rd;

  // R2
  prog_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_load |=> !ready_o);

  // R6
  vpp_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !vpp_ok_i && wsm_q == WS_READY && cui_q != CS_IDLE) |=> ready_o);

  // R9
  susp_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wsm_q == WS_SUSPENDED) |-> (status[7] && status[6]));

  // R11
  susp_blk_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_commit && wsm_q == WS_PROG_SUSP) |-> (tgt_blk != erase_blk_q));
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb_top;
  localparam int ADDR_W    = 8;
  localparam int BLK_W     = 2;
  localparam int PROG_CYC  = 4;
  localparam int ERASE_CYC = 16;
  localparam int SUSP_LAT  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wdata = '0;
  logic              vpp_ok = 1'b1;
  logic              hv = 1'b0;
  logic [3:0]        lock = '0;
  logic [7:0]        rdata;
  logic              ready;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .PROG_CYC(PROG_CYC),
                   .ERASE_CYC(ERASE_CYC), .SUSP_LAT(SUSP_LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .vpp_ok_i(vpp_ok), .hv_override_i(hv), .lock_i(lock),
    .rdata_o(rdata), .ready_o(ready));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a falling edge, returns at the falling edge after the write edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 ready", {7'd0, ready}, 8'h01);
    rd(8'h00, v); chk("R1 array", v, 8'hFF);
    rd(8'hC3, v); chk("R1 array", v, 8'hFF);
    wr(8'h00, 8'h70);
    rd(8'h00, v); chk("R1 status", v, 8'h80);
  endtask

  task automatic t_program();
    logic [7:0] v;
    wr(8'h05, 8'h40);
    wr(8'h05, 8'hA5);
    chk("R2 busy", {7'd0, ready}, 8'h00);
    rd(8'h05, v); chk("R3 status busy", v, 8'h00);
    wait_edges(PROG_CYC - 1);
    chk("R2 busy end", {7'd0, ready}, 8'h00);
    wait_edges(1);
    chk("R2 ready", {7'd0, ready}, 8'h01);
    rd(8'h05, v); chk("R3 status done", v, 8'h80);
    wr(8'h00, 8'hFF);
    rd(8'h05, v); chk("R2 data", v, 8'hA5);
    wr(8'h05, 8'h10);
    wr(8'h05, 8'h3C);
    wait_edges(PROG_CYC);
    rd(8'h05, v); chk("R2 alt status", v, 8'h80);
    wr(8'h00, 8'hFF);
    rd(8'h05, v); chk("R2 and", v, 8'h24);
  endtask

  task automatic t_erase();
    logic [7:0] v;
    wr(8'h45, 8'h40);
    wr(8'h45, 8'h00);
    wait_edges(PROG_CYC);
    wr(8'h40, 8'h20);
    wr(8'h40, 8'hD0);
    wait_edges(ERASE_CYC - 1);
    chk("R4 busy", {7'd0, ready}, 8'h00);
    wait_edges(1);
    chk("R4 ready", {7'd0, ready}, 8'h01);
    rd(8'h40, v); chk("R4 status", v, 8'h80);
    wr(8'h00, 8'hFF);
    rd(8'h45, v); chk("R4 filled", v, 8'hFF);
    rd(8'h05, v); chk("R4 other", v, 8'h24);
  endtask

  task automatic t_seq_err();
    logic [7:0] v;
    wr(8'h00, 8'h20);
    wr(8'h00, 8'h77);
    chk("R5 ready", {7'd0, ready}, 8'h01);
    rd(8'h00, v); chk("R5 status", v, 8'hB0);
    wr(8'h00, 8'hFF);
    rd(8'h05, v); chk("R5 array", v, 8'h24);
    wr(8'h00, 8'h70);
    rd(8'h00, v); chk("R8 sticky", v, 8'hB0);
    wr(8'h00, 8'h50);
    rd(8'h00, v); chk("R8 clear", v, 8'h80);
  endtask

  task automatic t_vpp();
    logic [7:0] v;
    vpp_ok = 1'b0;
    wr(8'h05, 8'h40);
    wr(8'h05, 8'h00);
    chk("R6 no busy", {7'd0, ready}, 8'h01);
    rd(8'h05, v); chk("R6 prog status", v, 8'h98);
    wr(8'h00, 8'h50);
    wr(8'h00, 8'h20);
    wr(8'h00, 8'hD0);
    rd(8'h00, v); chk("R6 erase status", v, 8'hA8);
    wr(8'h00, 8'hFF);
    rd(8'h05, v); chk("R6 array", v, 8'h24);
    wr(8'h00, 8'h50);
    vpp_ok = 1'b1;
  endtask

  task automatic t_lock();
    logic [7:0] v;
    lock = 4'b0100;
    wr(8'h80, 8'h40);
    wr(8'h80, 8'h00);
    rd(8'h80, v); chk("R7 prog locked", v, 8'h92);
    wr(8'h00, 8'h50);
    wr(8'h80, 8'h20);
    wr(8'h80, 8'hD0);
    rd(8'h80, v); chk("R7 erase locked", v, 8'hA2);
    wr(8'h00, 8'h50);
    hv = 1'b1;
    wr(8'h80, 8'h40);
    wr(8'h80, 8'h12);
    chk("R7 override busy", {7'd0, ready}, 8'h00);
    wait_edges(PROG_CYC);
    wr(8'h00, 8'hFF);
    rd(8'h80, v); chk("R7 override data", v, 8'h12);
    hv = 1'b0;
    lock = '0;
  endtask

  task automatic t_suspend();
    logic [7:0] v;
    wr(8'hC0, 8'h40);
    wr(8'hC0, 8'h55);
    wait_edges(PROG_CYC);
    wr(8'hC0, 8'h20);
    wr(8'hC0, 8'hD0);
    wait_edges(4);
    wr(8'hC0, 8'hB0);              // 5th running edge
    chk("R9 pending", {7'd0, ready}, 8'h00);
    wait_edges(SUSP_LAT - 1);
    chk("R9 pending end", {7'd0, ready}, 8'h00);
    wait_edges(1);
    chk("R9 ready", {7'd0, ready}, 8'h01);
    rd(8'hC0, v); chk("R9 status", v, 8'hC0);
    wr(8'h00, 8'hFF);
    rd(8'h80, v); chk("R10 read other", v, 8'h12);
    rd(8'hC1, v); chk("R11 read suspended blk", v, 8'hC0);
    wr(8'hC1, 8'h40);
    wr(8'hC1, 8'h00);
    chk("R11 no busy", {7'd0, ready}, 8'h01);
    rd(8'hC1, v); chk("R11 prog reject", v, 8'hD0);
    wr(8'h00, 8'h50);
    rd(8'h00, v); chk("R8 clear susp", v, 8'hC0);
    wr(8'h81, 8'h40);
    wr(8'h81, 8'h0F);
    rd(8'h81, v); chk("R10 prog busy", v, 8'h40);
    wait_edges(PROG_CYC - 1);
    chk("R10 busy end", {7'd0, ready}, 8'h00);
    wait_edges(1);
    rd(8'h81, v); chk("R10 prog done", v, 8'hC0);
    wr(8'h00, 8'hFF);
    rd(8'h81, v); chk("R10 prog data", v, 8'h0F);
    wr(8'h00, 8'hD0);
    rd(8'h00, v); chk("R12 resumed", v, 8'h00);
    wait_edges(ERASE_CYC - 5 - 1);
    chk("R12 busy", {7'd0, ready}, 8'h00);
    wait_edges(1);
    chk("R12 ready", {7'd0, ready}, 8'h01);
    rd(8'h00, v); chk("R12 status", v, 8'h80);
    wr(8'h00, 8'hFF);
    rd(8'hC0, v); chk("R12 erased", v, 8'hFF);
    rd(8'h80, v); chk("R12 other", v, 8'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_seq_err();
    t_vpp();
    t_lock();
    t_suspend();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule